// File: doc/BRIEF.md
# Two-Access Write Trap Unit

This block sits on an I/O write bus and watches for writes to a small set of legacy audio port addresses. Three of these ports are fixed at 388h, 38Ah and 38Bh. Three more sit in a relocatable group at 2x0h, 2x2h and 2x8h, where the digit x comes from a configuration input. Writes to these ports are trapped in pairs. The first matching write is recorded silently: its data byte and its address bit 1 are latched, and no event is raised. The second matching write raises a trap event and latches its data and its full address, as an ordinary trapped write would.

The trap event appears in two forms. One is a single-cycle pulse. The other is a sticky status bit that feeds the system-management interrupt status chain, and it stays set until that chain acknowledges it. Address bit 1 from the first access is kept in its own status output. Handler software places that output at bit 15 of its third-level status word. Deasserting the enable abandons a half-finished pair.

Top module: `twowr_trap`

## Requirements
- R1: After reset, trap_pulse, trap_sts, pending, first_a1, cap_data and cap_addr are all zero.
- R2: Writes to 388h, 38Ah and 38Bh match. Neighbouring addresses such as 389h do not match. An address with any bit set above bit 9 never matches.
- R3: Writes to 2x0h, 2x2h and 2x8h match when x (address bits [7:4]) equals base_digit and address bits [9:8] are 2'b10. Any other low nibble or digit does not match.
- R4: A matching write while pending is 0 sets pending, loads cap_data with the data and first_a1 with address bit 1, and leaves cap_addr unchanged. trap_pulse stays low on the following cycle.
- R5: A matching write while pending is 1 clears pending, raises trap_pulse for exactly the next cycle, sets trap_sts, and loads cap_data and cap_addr from that write.
- R6: trap_sts stays set until sts_clr is high on a clock edge. If a second access and sts_clr occur in the same cycle, the set wins.
- R7: Cycles with io_wr low, and writes to addresses that do not match, change none of pending, cap_data, cap_addr or first_a1.
- R8: While fp_en is low, pending clears on the next edge and matching writes are ignored. When fp_en returns high, the next matching write is treated as a first access.
- R9: The second access of a pair leaves first_a1 at the value captured by the first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fp_en | input | 1 | Enables two-access trapping |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_addr | input | ADDR_W | I/O write address |
| io_wdata | input | DATA_W | I/O write data |
| base_digit | input | 4 | Digit x for the 2x-series ports |
| sts_clr | input | 1 | Acknowledge that clears trap_sts |
| trap_pulse | output | 1 | One-cycle trap event |
| trap_sts | output | 1 | Sticky trap status to the SMI chain |
| pending | output | 1 | First access seen, waiting for the second |
| cap_data | output | DATA_W | Last captured write data |
| cap_addr | output | ADDR_W | Address captured by the last second access |
| first_a1 | output | 1 | Address bit 1 of the last first access |

## Verification
The hardest case is a second access that lands in the same cycle as the status acknowledge. To build it, the bench must first complete one pair so that trap_sts is set, then open a new pair, and only then issue the second write with sts_clr held high. A directed task does this in order. Two other cases also need a pending state to exist before the stimulus arrives. One is a cycle where fp_en drops while a pair is half done. The other is a write to a non-matching address placed between the two halves of a pair. Both are built the same way, by opening a pair with one first access before the stimulus is applied.

// File: rtl/twowr_trap_pkg.sv
package twowr_trap_pkg;

    localparam int unsigned DEC_W = 10;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_FIRST  = 2'd1,
        EV_SECOND = 2'd2
    } trap_ev_e;

    typedef struct packed {
        logic pend;
        logic pulse;
        logic sts;
    } seq_state_t;

endpackage

// File: rtl/twowr_trap_decode.sv
module twowr_trap_decode #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        base_digit,
    output logic              hit
);
    import twowr_trap_pkg::*;

    localparam int unsigned N_FIXED = 3;
    localparam logic [DEC_W-1:0] FIXED_PORT [N_FIXED] = '{10'h388, 10'h38A, 10'h38B};
    localparam int unsigned N_NIB = 3;
    localparam logic [3:0] SER_NIB [N_NIB] = '{4'h0, 4'h2, 4'h8};

    logic             upper_zero;
    logic [DEC_W-1:0] low;
    logic [N_FIXED-1:0] fixed_hit;
    logic [N_NIB-1:0]   nib_hit;
    logic             series_hit;

    assign low = addr[DEC_W-1:0];

    generate
        if (ADDR_W > DEC_W) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:DEC_W] == '0);
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
        for (genvar i = 0; i < N_FIXED; i++) begin : g_fixed
            assign fixed_hit[i] = (low == FIXED_PORT[i]);
        end
        for (genvar j = 0; j < N_NIB; j++) begin : g_nib
            assign nib_hit[j] = (low[3:0] == SER_NIB[j]);
        end
    endgenerate

    always_comb begin
        series_hit = (low[9:8] == 2'b10) && (low[7:4] == base_digit) && (|nib_hit);
        hit        = upper_zero && ((|fixed_hit) || series_hit);
    end

endmodule

// File: rtl/twowr_trap_seq.sv
module twowr_trap_seq (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fp_en,
    input  logic                      io_wr,
    input  logic                      hit,
    input  logic                      sts_clr,
    output logic                      pending,
    output logic                      trap_pulse,
    output logic                      trap_sts,
    output twowr_trap_pkg::trap_ev_e  ev
);
    import twowr_trap_pkg::*;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        ev         = EV_NONE;
        if (!fp_en) begin
            st_d.pend = 1'b0;
        end else if (io_wr && hit) begin
            if (!st_q.pend) begin
                st_d.pend = 1'b1;
                ev        = EV_FIRST;
            end else begin
                st_d.pend  = 1'b0;
                st_d.pulse = 1'b1;
                ev         = EV_SECOND;
            end
        end
        if (sts_clr) begin
            st_d.sts = 1'b0;
        end
        if (ev == EV_SECOND) begin
            st_d.sts = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending    = st_q.pend;
    assign trap_pulse = st_q.pulse;
    assign trap_sts   = st_q.sts;

endmodule

// File: rtl/twowr_trap_capture.sv
module twowr_trap_capture #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  twowr_trap_pkg::trap_ev_e ev,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        cap_data,
    output logic [ADDR_W-1:0]        cap_addr,
    output logic                     first_a1
);
    import twowr_trap_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              a1;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        case (ev)
            EV_FIRST: begin
                cap_d.data = wdata;
                cap_d.a1   = addr[1];
            end
            EV_SECOND: begin
                cap_d.data = wdata;
                cap_d.addr = addr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cap_data = cap_q.data;
    assign cap_addr = cap_q.addr;
    assign first_a1 = cap_q.a1;

endmodule

// File: rtl/twowr_trap.sv
module twowr_trap #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_en,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [3:0]        base_digit,
    input  logic              sts_clr,
    output logic              trap_pulse,
    output logic              trap_sts,
    output logic              pending,
    output logic [DATA_W-1:0] cap_data,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              first_a1
);
    import twowr_trap_pkg::*;

    logic     addr_hit;
    trap_ev_e ev;

    twowr_trap_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr       (io_addr),
        .base_digit (base_digit),
        .hit        (addr_hit)
    );

    twowr_trap_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_en      (fp_en),
        .io_wr      (io_wr),
        .hit        (addr_hit),
        .sts_clr    (sts_clr),
        .pending    (pending),
        .trap_pulse (trap_pulse),
        .trap_sts   (trap_sts),
        .ev         (ev)
    );

    twowr_trap_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .addr     (io_addr),
        .wdata    (io_wdata),
        .cap_data (cap_data),
        .cap_addr (cap_addr),
        .first_a1 (first_a1)
    );

endmodule

// File: rtl/twowr_trap_chk.sv
module twowr_trap_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fp_en,
    input logic              io_wr,
    input logic              addr_hit,
    input logic              sts_clr,
    input logic              trap_pulse,
    input logic              trap_sts,
    input logic              pending,
    input logic [DATA_W-1:0] cap_data,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              first_a1
);

    a_r4_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_en && io_wr && addr_hit && !pending) |=> (!trap_pulse && pending));

    a_r5_second_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_en && io_wr && addr_hit && pending) |=> (trap_pulse && trap_sts && !pending));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> !trap_pulse);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_sts && !sts_clr) |=> trap_sts);

    a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_en && !(io_wr && addr_hit)) |=> $stable(pending));

    a_r7_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !(fp_en && io_wr && addr_hit) |=> ($stable(cap_data) && $stable(cap_addr) && $stable(first_a1)));

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_en |=> (!pending && !trap_pulse));

    a_r9_a1_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_en && io_wr && addr_hit && pending) |=> $stable(first_a1));

endmodule

bind twowr_trap twowr_trap_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fp_en      (fp_en),
    .io_wr      (io_wr),
    .addr_hit   (addr_hit),
    .sts_clr    (sts_clr),
    .trap_pulse (trap_pulse),
    .trap_sts   (trap_sts),
    .pending    (pending),
    .cap_data   (cap_data),
    .cap_addr   (cap_addr),
    .first_a1   (first_a1)
);

// File: tb/twowr_trap_bench.sv
module twowr_trap_bench;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fp_en = 1'b0;
    logic              io_wr = 1'b0;
    logic [ADDR_W-1:0] io_addr = '0;
    logic [DATA_W-1:0] io_wdata = '0;
    logic [3:0]        base_digit = 4'h2;
    logic              sts_clr = 1'b0;
    logic              trap_pulse, trap_sts, pending, first_a1;
    logic [DATA_W-1:0] cap_data;
    logic [ADDR_W-1:0] cap_addr;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    twowr_trap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_twowr_trap (
        .clk(clk), .rst_n(rst_n), .fp_en(fp_en), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .base_digit(base_digit),
        .sts_clr(sts_clr), .trap_pulse(trap_pulse), .trap_sts(trap_sts),
        .pending(pending), .cap_data(cap_data), .cap_addr(cap_addr),
        .first_a1(first_a1)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One write cycle; returns at the negedge after the capturing edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic clr);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d; sts_clr = clr;
        @(negedge clk);
        io_wr = 1'b0; sts_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "trap_pulse", trap_pulse, 0);
        chk("R1", "trap_sts", trap_sts, 0);
        chk("R1", "pending", pending, 0);
        chk("R1", "first_a1", first_a1, 0);
        chk("R1", "cap_data", cap_data, 0);
        chk("R1", "cap_addr", cap_addr, 0);
    endtask

    task automatic t_fixed_pair;
        wr(16'h0388, 8'hAA, 0);
        chk("R4", "pending after first", pending, 1);
        chk("R4", "no pulse on first", trap_pulse, 0);
        chk("R4", "cap_data first", cap_data, 8'hAA);
        chk("R4", "first_a1 from 388", first_a1, 0);
        chk("R4", "cap_addr untouched", cap_addr, 0);
        chk("R2", "trap_sts after first", trap_sts, 0);
        wr(16'h038A, 8'h55, 0);
        chk("R5", "pulse on second", trap_pulse, 1);
        chk("R5", "sts set", trap_sts, 1);
        chk("R5", "pending cleared", pending, 0);
        chk("R5", "cap_data second", cap_data, 8'h55);
        chk("R5", "cap_addr second", cap_addr, 16'h038A);
        chk("R9", "first_a1 kept", first_a1, 0);
        idle(1);
        chk("R5", "pulse one cycle", trap_pulse, 0);
        chk("R6", "sts sticky", trap_sts, 1);
        idle(3);
        chk("R6", "sts still sticky", trap_sts, 1);
        @(negedge clk); sts_clr = 1'b1;
        @(negedge clk); sts_clr = 1'b0;
        chk("R6", "sts cleared", trap_sts, 0);
    endtask

    task automatic t_nonmatch_between;
        wr(16'h038B, 8'h11, 0);
        chk("R4", "first_a1 from 38B", first_a1, 1);
        chk("R2", "38B opens pair", pending, 1);
        wr(16'h0389, 8'hEE, 0);
        chk("R2", "389 ignored pending", pending, 1);
        chk("R7", "389 data ignored", cap_data, 8'h11);
        wr(16'h1388, 8'hEE, 0);
        chk("R2", "upper bit ignored", pending, 1);
        chk("R7", "upper bit data ignored", cap_data, 8'h11);
        @(negedge clk); io_addr = 16'h0388; io_wdata = 8'h77;
        idle(3);
        chk("R7", "strobe low pending", pending, 1);
        chk("R7", "strobe low data", cap_data, 8'h11);
        wr(16'h0388, 8'h22, 0);
        chk("R5", "second after gaps", trap_pulse, 1);
        chk("R9", "first_a1 stays 1", first_a1, 1);
        chk("R5", "cap_addr 388", cap_addr, 16'h0388);
        @(negedge clk); sts_clr = 1'b1;
        @(negedge clk); sts_clr = 1'b0;
    endtask

    task automatic t_series;
        base_digit = 4'h5;
        wr(16'h0250, 8'h01, 0);
        chk("R3", "250 opens pair", pending, 1);
        wr(16'h0254, 8'h02, 0);
        chk("R3", "254 ignored", pending, 1);
        chk("R3", "254 data ignored", cap_data, 8'h01);
        wr(16'h0260, 8'h03, 0);
        chk("R3", "wrong digit ignored", pending, 1);
        wr(16'h0350, 8'h04, 0);
        chk("R3", "wrong bits 9:8 ignored", pending, 1);
        wr(16'h0258, 8'h05, 0);
        chk("R3", "258 closes pair", trap_pulse, 1);
        chk("R3", "cap_addr 258", cap_addr, 16'h0258);
        wr(16'h0252, 8'h06, 0);
        chk("R3", "252 a1", first_a1, 1);
        base_digit = 4'h7;
        wr(16'h0272, 8'h07, 0);
        chk("R3", "new digit 272 traps", trap_pulse, 1);
        chk("R3", "cap_addr 272", cap_addr, 16'h0272);
        chk("R3", "cap_data 272", cap_data, 8'h07);
        @(negedge clk); sts_clr = 1'b1;
        @(negedge clk); sts_clr = 1'b0;
    endtask

    task automatic t_disable;
        base_digit = 4'h2;
        wr(16'h0220, 8'h31, 0);
        chk("R8", "pair open", pending, 1);
        @(negedge clk); fp_en = 1'b0;
        @(negedge clk);
        chk("R8", "pending cleared by disable", pending, 0);
        wr(16'h0388, 8'h32, 0);
        chk("R8", "no trap while off", trap_pulse, 0);
        chk("R8", "no pend while off", pending, 0);
        chk("R8", "data unchanged while off", cap_data, 8'h31);
        @(negedge clk); fp_en = 1'b1;
        wr(16'h0228, 8'h33, 0);
        chk("R8", "restart is first access", trap_pulse, 0);
        chk("R8", "restart pending", pending, 1);
        chk("R8", "restart data", cap_data, 8'h33);
        chk("R8", "sts never set", trap_sts, 0);
        wr(16'h0222, 8'h34, 0);
        chk("R8", "pair completes", trap_pulse, 1);
    endtask

    task automatic t_set_beats_clear;
        chk("R6", "sts set before", trap_sts, 1);
        wr(16'h038A, 8'h41, 0);
        chk("R6", "pair open", pending, 1);
        wr(16'h038B, 8'h42, 1);
        chk("R6", "set wins over clear", trap_sts, 1);
        chk("R5", "pulse with clear", trap_pulse, 1);
        @(negedge clk); sts_clr = 1'b1;
        @(negedge clk); sts_clr = 1'b0;
        chk("R6", "plain clear", trap_sts, 0);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(2);
        t_reset();
        @(negedge clk); rst_n = 1'b1; fp_en = 1'b1;
        idle(1);
        t_fixed_pair();
        t_nonmatch_between();
        t_series();
        t_disable();
        t_set_beats_clear();
        idle(2);
        finish_run();
    end

endmodule